// File: doc/BRIEF.md
# Burst-Capable Synchronous SRAM Core

This block is a clocked single-port memory organised as a cache RAM. Each word is built from byte lanes. The default is two 9-bit lanes, which gives an 18-bit word. A start address is captured on a rising edge under either of two address strobes. The first is a processor strobe, which is honoured only when the primary chip select is active. The second is a controller strobe, which is always honoured. The low two address bits then step through a four-beat group under an advance input. A mode pin picks the stepping order: XOR-interleaved or modulo-4 linear.

Read data is flow-through. It is valid in the cycle right after the capture edge, and each later beat follows one cycle apart. Counting the cycle in which the address is presented, this gives a 2-1-1-1 access pattern. Writes happen on the edges that follow a capture. A global write control stores every lane. A byte-write enable together with per-lane enables stores a chosen subset of lanes.

An asynchronous output enable gates the read port without any clock. A sleep input tri-states the read port and freezes all state while it is high, and the memory keeps its contents. Because the block has no bidirectional pins, the tri-state condition is reported on a drive-enable output, and the data output reads zero while that output is low.

Top module: `burst_sram`

## Requirements
- R1: On a rising edge with `sleep` low, a new start address is captured from `addr`. This happens when `ctl_strobe_n` is low, or when `cpu_strobe_n` is low and `sel1_n` is low. After the capture, the beat index is 0 and the current address equals the captured address.
- R2: When the capture edge saw `sel1_n`=0, `sel2`=1 and `sel3_n`=0, the burst is selected. In the cycle after that edge, `rd_drive` is 1 (given `out_en_n`=0 and `sleep`=0). In that same cycle, `rd_data` shows the stored word at the current address.
- R3: With `order_il`=0, the current low two address bits equal the start bits plus the beat index, modulo 4. The upper address bits never change within a burst.
- R4: With `order_il`=1, the current low two address bits equal the start bits XOR the beat index.
- R5: The beat index advances by one, wrapping from 3 to 0, on a non-capture edge of a selected burst where `adv_n` is low. When `adv_n` is high, or `sleep` is high, the beat index holds.
- R6: On a non-capture edge of a selected burst, `glb_wr_n`=0 writes the whole `wr_data` to the current address. The write uses the address in effect before any advance on that same edge.
- R7: With `glb_wr_n`=1 and `byte_wr_n`=0, only the lanes whose `lane_wr_n` bit is low are written. Lane 0 is data bits 8:0 and lane 1 is bits 17:9. With `glb_wr_n`=1 and `byte_wr_n`=1, the cycle is a read and memory is unchanged.
- R8: A processor-strobe edge with `sel1_n`=1 and `ctl_strobe_n`=1 is ignored, and the running burst continues. A controller-strobe capture with any chip select inactive deselects the burst. A deselected burst sets `rd_drive` to 0 and writes nothing.
- R9: `out_en_n`=1 forces `rd_drive` to 0 and `rd_data` to 0 combinationally, with no clock edge involved.
- R10: While `sleep` is high, `rd_drive` is 0 and edges perform no capture, write or advance, and memory contents are kept. Normal operation resumes on the first edge that sees `sleep` low.
- R11: After reset, no burst is selected and `rd_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of burst state |
| addr | input | AW | Word address, sampled on a capture edge |
| wr_data | input | LANES*LANE_W | Write data |
| sel1_n | input | 1 | Primary chip select, active low, also gates the processor strobe |
| sel2 | input | 1 | Expansion chip select, active high |
| sel3_n | input | 1 | Expansion chip select, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| byte_wr_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| glb_wr_n | input | 1 | Global write of all lanes, active low |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| rd_data | output | LANES*LANE_W | Flow-through read data, zero while not driven |
| rd_drive | output | 1 | Read port drive enable, low means tri-stated |

## Verification
The bench targets four areas:
- **Burst wrap point.** It uses starts at offsets 2 and 3 under both orderings, and runs a fifth beat. A counter that carried into the upper address bits, or that confused linear with XOR ordering, would read the wrong group's word.
- **Write timing and lane masks.** It writes on the same edge as an advance, and performs single-lane writes followed by a plain read. A write placed after the advance, or a lane decoded from the wrong enable bit, would leave a corrupted word that shows up on read-back.
- **Processor strobe with the primary select inactive.** This must leave a running burst untouched, while a controller strobe with an expansion select inactive must silence the read port. A design that treated the two strobes alike fails one of these.
- **Sleep over a capture and a write, and mid-cycle output enable.** These expose state that moves during sleep, and an output enable that waits for a clock.

// File: rtl/sram_pkg.sv
package sram_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;

   localparam int GROUP_W = 2;

   function automatic logic [GROUP_W-1:0] beat_offset(
      input logic [GROUP_W-1:0] start,
      input logic [GROUP_W-1:0] beat,
      input order_e             ord
   );
      if (ord == ORD_INTERLEAVE)
         return start ^ beat;
      else
         return start + beat;
   endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import sram_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          sel1_n,
   input  logic          sel2,
   input  logic          sel3_n,
   input  logic          cpu_strobe_n,
   input  logic          ctl_strobe_n,
   input  logic          adv_n,
   input  logic          order_il,
   input  logic          sleep,
   output logic          cap,
   output logic          act,
   output logic [GROUP_W-1:0] beat,
   output logic [AW-1:0] cur_addr
);

   logic          sel_all;
   logic [AW-1:0] base;

   always_comb begin
      cap     = !sleep && (!ctl_strobe_n || (!cpu_strobe_n && !sel1_n));
      sel_all = !sel1_n && sel2 && !sel3_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act  <= 1'b0;
         beat <= '0;
         base <= '0;
      end else if (cap) begin
         act  <= sel_all;
         beat <= '0;
         base <= addr;
      end else if (!sleep && act && !adv_n) begin
         beat <= beat + 1'b1;
      end
   end

   always_comb
      cur_addr = {base[AW-1:GROUP_W],
                  beat_offset(base[GROUP_W-1:0], beat, order_e'(order_il))};

endmodule

// File: rtl/lane_write_dec.sv
module lane_write_dec #(
   parameter int LANES = 2
) (
   input  logic             wr_ok,
   input  logic             glb_wr_n,
   input  logic             byte_wr_n,
   input  logic [LANES-1:0] lane_wr_n,
   output logic [LANES-1:0] lane_we
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_comb
         lane_we[g] = wr_ok && (!glb_wr_n || (!byte_wr_n && !lane_wr_n[g]));
   end

endmodule

// File: rtl/sram_lanes.sv
module sram_lanes #(
   parameter int DEPTH  = 256,
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        lane_we,
   input  logic [AW-1:0]           addr,
   input  logic [LANES*LANE_W-1:0] wr_data,
   output logic [LANES*LANE_W-1:0] rd_word
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk)
         if (lane_we[g])
            store[addr] <= wr_data[g*LANE_W +: LANE_W];

      always_comb
         rd_word[g*LANE_W +: LANE_W] = store[addr];
   end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import sram_pkg::*;
#(
   parameter int DEPTH  = 256,
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   parameter int AW     = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [AW-1:0]           addr,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic                    sel1_n,
   input  logic                    sel2,
   input  logic                    sel3_n,
   input  logic                    cpu_strobe_n,
   input  logic                    ctl_strobe_n,
   input  logic                    adv_n,
   input  logic                    byte_wr_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic                    glb_wr_n,
   input  logic                    order_il,
   input  logic                    out_en_n,
   input  logic                    sleep,
   output logic [LANES*LANE_W-1:0] rd_data,
   output logic                    rd_drive
);

   localparam int WORD_W = LANES * LANE_W;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (AW != $clog2(DEPTH)) begin : g_bad_aw
      $error("AW must equal clog2(DEPTH)");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("LANES and LANE_W must be positive");
   end

   logic               cap;
   logic               act;
   logic [GROUP_W-1:0] beat;
   logic [AW-1:0]      cur_addr;
   logic [LANES-1:0]   lane_we;
   logic [WORD_W-1:0]  rd_word;
   logic               wr_ok;

   burst_addr_gen #(.AW(AW)) u_addr (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr         (addr),
      .sel1_n       (sel1_n),
      .sel2         (sel2),
      .sel3_n       (sel3_n),
      .cpu_strobe_n (cpu_strobe_n),
      .ctl_strobe_n (ctl_strobe_n),
      .adv_n        (adv_n),
      .order_il     (order_il),
      .sleep        (sleep),
      .cap          (cap),
      .act          (act),
      .beat         (beat),
      .cur_addr     (cur_addr)
   );

   always_comb wr_ok = act && !cap && !sleep;

   lane_write_dec #(.LANES(LANES)) u_wdec (
      .wr_ok     (wr_ok),
      .glb_wr_n  (glb_wr_n),
      .byte_wr_n (byte_wr_n),
      .lane_wr_n (lane_wr_n),
      .lane_we   (lane_we)
   );

   sram_lanes #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_mem (
      .clk     (clk),
      .lane_we (lane_we),
      .addr    (cur_addr),
      .wr_data (wr_data),
      .rd_word (rd_word)
   );

   always_comb begin
      rd_drive = act && !out_en_n && !sleep;
      rd_data  = rd_drive ? rd_word : '0;
   end

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] addr,
   input logic          sel1_n,
   input logic          cpu_strobe_n,
   input logic          ctl_strobe_n,
   input logic          adv_n,
   input logic          out_en_n,
   input logic          sleep,
   input logic          act,
   input logic [1:0]    beat,
   input logic [AW-1:0] cur_addr,
   input logic          rd_drive
);

   // R1
   cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !ctl_strobe_n) |=> (cur_addr == $past(addr) && beat == 2'd0));

   // R5
   adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && act && ctl_strobe_n && cpu_strobe_n && !adv_n)
      |=> (beat == $past(beat) + 2'd1));

   // R5
   adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && ctl_strobe_n && cpu_strobe_n && adv_n)
      |=> ($stable(beat) && $stable(act)));

   // R8
   cpu_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && ctl_strobe_n && !cpu_strobe_n && sel1_n)
      |=> ($stable(act) && $stable(cur_addr[AW-1:2])));

   // R9
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !rd_drive);

   // R10
   sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> ($stable(act) && $stable(beat) && $stable(cur_addr[AW-1:2])));

   // R10
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !rd_drive);

endmodule

bind burst_sram burst_sram_chk #(.AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .addr         (addr),
   .sel1_n       (sel1_n),
   .cpu_strobe_n (cpu_strobe_n),
   .ctl_strobe_n (ctl_strobe_n),
   .adv_n        (adv_n),
   .out_en_n     (out_en_n),
   .sleep        (sleep),
   .act          (act),
   .beat         (beat),
   .cur_addr     (cur_addr),
   .rd_drive     (rd_drive)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;

   localparam int PERIOD = 10;
   localparam int DEPTH  = 256;
   localparam int AW     = 8;
   localparam int W      = 18;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic [W-1:0]  wr_data;
   logic          sel1_n, sel2, sel3_n;
   logic          cpu_strobe_n, ctl_strobe_n, adv_n;
   logic          byte_wr_n, glb_wr_n, order_il, out_en_n, sleep;
   logic [1:0]    lane_wr_n;
   logic [W-1:0]  rd_data;
   logic          rd_drive;

   int checks = 0;
   int errors = 0;

   // reference model state
   int m_act, m_base, m_beat;
   int m_mem [DEPTH];
   bit m_known [DEPTH];

   always #(PERIOD/2) clk = ~clk;

   burst_sram #(.DEPTH(DEPTH), .LANES(2), .LANE_W(9)) i_burst_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
      .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
      .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
      .adv_n(adv_n), .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n),
      .glb_wr_n(glb_wr_n), .order_il(order_il), .out_en_n(out_en_n),
      .sleep(sleep), .rd_data(rd_data), .rd_drive(rd_drive)
   );

   task automatic check(input string tag, input bit ok,
                        input int act_v, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act_v, exp_v);
      end
   endtask

   function automatic int cur_addr_m();
      int lo;
      if (order_il) lo = (m_base & 3) ^ m_beat;
      else          lo = ((m_base & 3) + m_beat) & 3;
      return (m_base & ~3) | lo;
   endfunction

   task automatic model_edge();
      bit cap;
      int a, v;
      cap = !sleep && (!ctl_strobe_n || (!cpu_strobe_n && !sel1_n));
      if (cap) begin
         m_act  = (!sel1_n && sel2 && !sel3_n) ? 1 : 0;
         m_base = int'(addr);
         m_beat = 0;
      end else if (!sleep && m_act != 0) begin
         a = cur_addr_m();
         v = m_mem[a];
         if (!glb_wr_n) begin
            v = int'(wr_data);
            m_known[a] = 1'b1;
         end else if (!byte_wr_n) begin
            if (!lane_wr_n[0]) v = (v & 32'h3FE00) | int'(wr_data[8:0]);
            if (!lane_wr_n[1]) v = (v & 32'h001FF) | (int'(wr_data[17:9]) << 9);
         end
         m_mem[a] = v;
         if (!adv_n) m_beat = (m_beat + 1) & 3;
      end
   endtask

   task automatic compare(input string tag);
      bit exp_drv;
      int a;
      exp_drv = (m_act != 0) && !out_en_n && !sleep;
      check(tag, rd_drive == exp_drv, int'(rd_drive), int'(exp_drv));
      a = cur_addr_m();
      if (exp_drv && m_known[a])
         check(tag, rd_data == W'(m_mem[a]), int'(rd_data), m_mem[a]);
      else if (!exp_drv)
         check(tag, rd_data == '0, int'(rd_data), 0);
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle();
      cpu_strobe_n = 1; ctl_strobe_n = 1; adv_n = 1;
      glb_wr_n = 1; byte_wr_n = 1; lane_wr_n = 2'b11;
      sel1_n = 0; sel2 = 1; sel3_n = 0; out_en_n = 0; sleep = 0;
   endtask

   task automatic start_ctl(input int a, input string tag);
      addr = AW'(a); ctl_strobe_n = 0;
      step(tag);
      ctl_strobe_n = 1;
   endtask

   function automatic logic [W-1:0] pat(input int a);
      return W'((a * 1237 + 91) ^ (a << 10));
   endfunction

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] r;
      idle();
      order_il = 0; addr = '0; wr_data = '0;
      m_act = 0; m_base = 0; m_beat = 0;
      for (int i = 0; i < DEPTH; i++) begin m_mem[i] = 0; m_known[i] = 0; end
      rst_n = 0;
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11", rd_drive == 1'b0, int'(rd_drive), 0);
      check("R11", rd_data == '0, int'(rd_data), 0);
      rst_n = 1;
      @(negedge clk);

      // R6 fill memory with global writes, linear bursts
      for (int b = 0; b < DEPTH / 4; b++) begin
         start_ctl(b * 4, "R6");
         glb_wr_n = 0; adv_n = 0;
         for (int k = 0; k < 4; k++) begin
            wr_data = pat(b * 4 + k);
            step("R6");
         end
         idle();
      end

      // R2 R3 R5 linear read from offset 2, five beats to show wrap
      order_il = 0;
      start_ctl(8'h26, "R2");
      adv_n = 0;
      for (int k = 0; k < 5; k++) step("R3");
      adv_n = 1;
      step("R5"); step("R5");

      // R4 interleaved read from offset 3
      order_il = 1;
      start_ctl(8'h4B, "R2");
      adv_n = 0;
      for (int k = 0; k < 5; k++) step("R4");
      idle();

      // R7 lane writes then plain read
      order_il = 0;
      start_ctl(8'h31, "R7");
      byte_wr_n = 0; lane_wr_n = 2'b10; wr_data = 18'h2A5A5;
      step("R7");
      lane_wr_n = 2'b01; wr_data = 18'h15A5A; adv_n = 0;
      step("R7");
      byte_wr_n = 1; lane_wr_n = 2'b00; wr_data = 18'h3FFFF;
      step("R7");
      idle();
      start_ctl(8'h31, "R7");
      adv_n = 0;
      for (int k = 0; k < 4; k++) step("R7");
      idle();

      // R1 processor strobe capture with select active
      addr = 8'h62; cpu_strobe_n = 0;
      step("R1");
      cpu_strobe_n = 1; adv_n = 0;
      step("R1");
      // R8 processor strobe with sel1_n high is ignored
      sel1_n = 1; cpu_strobe_n = 0; addr = 8'h90; adv_n = 1;
      step("R8");
      sel1_n = 0; cpu_strobe_n = 1; adv_n = 0;
      step("R8");
      // R8 controller strobe with expansion select inactive deselects
      adv_n = 1; sel2 = 0;
      start_ctl(8'h10, "R8");
      sel2 = 1; glb_wr_n = 0; wr_data = 18'h00001;
      step("R8");
      idle();
      start_ctl(8'h10, "R8");

      // R9 asynchronous output enable, mid-cycle
      out_en_n = 1; #1;
      check("R9", rd_drive == 1'b0, int'(rd_drive), 0);
      check("R9", rd_data == '0, int'(rd_data), 0);
      out_en_n = 0; #1;
      check("R9", rd_drive == 1'b1, int'(rd_drive), 1);
      check("R9", rd_data == pat(8'h10), int'(rd_data), int'(pat(8'h10)));

      // R10 sleep over capture, write and advance
      sleep = 1;
      step("R10");
      ctl_strobe_n = 0; addr = 8'hA0;
      step("R10");
      ctl_strobe_n = 1; glb_wr_n = 0; adv_n = 0; wr_data = 18'h3C3C3;
      step("R10");
      glb_wr_n = 1; adv_n = 1; sleep = 0;
      step("R10");
      adv_n = 0;
      for (int k = 0; k < 4; k++) step("R10");
      idle();

      // R2 mixed pseudo-random traffic
      r = 32'h1D2C3B4A;
      for (int i = 0; i < 400; i++) begin
         r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
         ctl_strobe_n = r[0] | r[1] | r[2];
         cpu_strobe_n = r[3] | r[4];
         sel1_n       = r[5] & r[6];
         sel2         = !(r[7] & r[8] & r[9]);
         adv_n        = r[10];
         glb_wr_n     = r[11] | r[12];
         byte_wr_n    = r[13];
         lane_wr_n    = r[15:14];
         out_en_n     = r[16] & r[17];
         sleep        = r[18] & r[19] & r[20];
         order_il     = r[21];
         addr         = r[29:22];
         wr_data      = W'(r * 32'h9E37);
         step("R2");
      end
      idle();
      step("R2");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule